// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Level Flags

This block is a first-in first-out buffer with a write port and a read port on unrelated clocks. The read timing is fixed at master reset. In standard timing a word reaches the output register only when the consumer asks for it. In fall-through timing the head word is placed on the output without a request, and each later word follows one request.

Two status pins change meaning with the timing mode. The output-side pin reports empty in standard timing and word-valid in fall-through timing. The input-side pin reports full in standard timing and space-available in fall-through timing. Three level flags are present in both modes: half-full, almost-empty and almost-full. The two almost thresholds live in an offset register. Master reset sets it to parameter defaults, and a write-domain load strobe replaces it.

A partial reset empties the buffer but keeps the timing mode and the offsets. Master reset clears everything. Depth, width, synchronizer length and default offsets are parameters.

Top module: `fifo_dualmode`

## Requirements
- R1: The level of `fall_thru_sel` while `mrst_n` is low picks the timing: 0 gives standard, 1 gives fall-through. Changes of `fall_thru_sel` at any other time have no effect until the next master reset.
- R2: In standard timing, `rd_data` changes only at a `rd_clk` rising edge where `rd_en` is 1 and the buffer is not empty. It then takes the oldest stored word.
- R3: In fall-through timing, a word written into an empty buffer appears on `rd_data` with `out_flag` at 1 on the third `rd_clk` rising edge after the write edge, with `rd_en` held at 0.
- R4: In fall-through timing, a presented word stays on `rd_data` until a `rd_clk` edge with `rd_en` at 1. That edge presents the next word, or drops `out_flag` to 0 if none is stored.
- R5: In standard timing, `out_flag`=1 means empty and `in_flag`=1 means full. In fall-through timing, `out_flag`=1 means a valid word is on `rd_data` and `in_flag`=1 means a write is accepted.
- R6: A write while the storage is full is dropped, and a standard-mode read while empty is dropped. Neither moves a pointer nor alters `rd_data` or later read data.
- R7: `half_full` is 1 when the write domain's word count exceeds DEPTH/2.
- R8: `almost_full` is 1 when free locations are at most the full offset. `almost_empty` is 1 when readable words are at most the empty offset. A write-clock edge with `ofs_load`=1 loads `ofs_ae` and `ofs_af` as the new offsets.
- R9: Master reset empties the buffer and restores both offsets to `AE_DEF` and `AF_DEF`.
- R10: Partial reset empties the buffer, so the next word is taken from the first location. It keeps the timing mode and the loaded offsets.
- R11: Words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, asynchronous assert |
| fall_thru_sel | input | 1 | Timing select sampled during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write word |
| ofs_load | input | 1 | Load strobe for both offsets (write clock) |
| ofs_ae | input | ADDR_W | New almost-empty offset |
| ofs_af | input | ADDR_W | New almost-full offset |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output word register |
| out_flag | output | 1 | Empty (standard) or word-valid (fall-through) |
| in_flag | output | 1 | Full (standard) or space-available (fall-through) |
| half_full | output | 1 | More than half the locations used |
| almost_empty | output | 1 | Readable words at or below empty offset |
| almost_full | output | 1 | Free locations at or below full offset |

## Verification
Two functions that can land in the same cycle are the fall-through refill of the output register and a consumer read of the presented word. The bench fills the buffer behind a held word and then pulses `rd_en`. The following word must replace the old one on that same edge with `out_flag` staying high, and a final read of the last word must drop `out_flag`. A second collision is a write arriving while the storage is full. The bench offers such words in both timings and then drains the buffer, confirming that the dropped value never appears and that the order is intact.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
   typedef enum logic {
      RD_STD  = 1'b0,
      RD_FWFT = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/fifo_rst_sync.sv
`timescale 1ns/1ps
module fifo_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/fifo_ptr_sync.sv
`timescale 1ns/1ps
module fifo_ptr_sync #(
   parameter int PW     = 5,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] bin_out
);
   logic [PW-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= gray_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   always_comb begin
      logic [PW-1:0] acc;
      acc[PW-1] = stg[STAGES-1][PW-1];
      for (int i = PW - 2; i >= 0; i--) acc[i] = acc[i+1] ^ stg[STAGES-1][i];
      bin_out = acc;
   end
endmodule

// File: rtl/fifo_dpram.sv
`timescale 1ns/1ps
module fifo_dpram #(
   parameter int DW = 16,
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rclk,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int WORDS = 1 << AW;
   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rclk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/fifo_dualmode.sv
`timescale 1ns/1ps
module fifo_dualmode
   import fifo_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int AE_DEF      = 2,
   parameter int AF_DEF      = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              fall_thru_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ofs_load,
   input  logic [ADDR_W-1:0] ofs_ae,
   input  logic [ADDR_W-1:0] ofs_af,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              out_flag,
   output logic              in_flag,
   output logic              half_full,
   output logic              almost_empty,
   output logic              almost_full
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PW    = ADDR_W + 1;

   generate
      if (ADDR_W < 2)          begin : g_bad_aw   $error("ADDR_W must be at least 2"); end
      if (SYNC_STAGES < 2)     begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
      if (AE_DEF >= DEPTH)     begin : g_bad_ae   $error("AE_DEF must be below DEPTH"); end
      if (AF_DEF >= DEPTH)     begin : g_bad_af   $error("AF_DEF must be below DEPTH"); end
   endgenerate

   // reset distribution
   logic any_rst_n, wm_rst_n, wp_rst_n, rm_rst_n, rp_rst_n;
   assign any_rst_n = mrst_n & prst_n;

   fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wm (.clk(wr_clk), .arst_n(mrst_n),    .srst_n(wm_rst_n));
   fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wp (.clk(wr_clk), .arst_n(any_rst_n), .srst_n(wp_rst_n));
   fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rm (.clk(rd_clk), .arst_n(mrst_n),    .srst_n(rm_rst_n));
   fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rp (.clk(rd_clk), .arst_n(any_rst_n), .srst_n(rp_rst_n));

   // ---------------- write domain ----------------
   rd_mode_e          mode_w;
   logic [ADDR_W-1:0] ae_q, af_q;
   logic [PW-1:0]     wbin, wgray, wbin_nx, rbin_w, wcount, wr_free;
   logic              full, wr_go;

   // mode and offsets survive partial reset; only master reset touches them
   always_ff @(posedge wr_clk) begin
      if (!wm_rst_n) begin
         mode_w <= rd_mode_e'(fall_thru_sel);
         ae_q   <= ADDR_W'(AE_DEF);
         af_q   <= ADDR_W'(AF_DEF);
      end else if (ofs_load) begin
         ae_q   <= ofs_ae;
         af_q   <= ofs_af;
      end
   end

   assign wcount  = wbin - rbin_w;
   assign full    = (wcount == PW'(DEPTH));
   assign wr_free = PW'(DEPTH) - wcount;
   assign wr_go   = wr_en && !full;
   assign wbin_nx = wbin + PW'(1);

   always_ff @(posedge wr_clk or negedge wp_rst_n) begin
      if (!wp_rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_go) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   assign in_flag     = (mode_w == RD_FWFT) ? !full : full;
   assign half_full   = (wcount > PW'(DEPTH / 2));
   assign almost_full = (wr_free <= {1'b0, af_q});

   // ---------------- read domain ----------------
   rd_mode_e      mode_r;
   logic [PW-1:0] rbin, rgray, rbin_nx, wbin_r, rcount, avail;
   logic          mem_has, rd_load, out_vld;

   always_ff @(posedge rd_clk) begin
      if (!rm_rst_n) mode_r <= rd_mode_e'(fall_thru_sel);
   end

   assign rcount  = wbin_r - rbin;
   assign mem_has = (rcount != '0);
   assign rbin_nx = rbin + PW'(1);

   always_comb begin
      if (mode_r == RD_FWFT) rd_load = mem_has && (!out_vld || rd_en);
      else                   rd_load = mem_has && rd_en;
   end

   always_ff @(posedge rd_clk or negedge rp_rst_n) begin
      if (!rp_rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         out_vld <= 1'b0;
      end else begin
         if (rd_load) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
         end
         if (rd_load)     out_vld <= 1'b1;
         else if (rd_en)  out_vld <= 1'b0;
      end
   end

   assign avail        = rcount + PW'(out_vld && (mode_r == RD_FWFT));
   assign almost_empty = (avail <= {1'b0, ae_q});
   assign out_flag     = (mode_r == RD_FWFT) ? out_vld : !mem_has;

   // ---------------- crossings and storage ----------------
   fifo_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wp_rst_n), .gray_in(rgray), .bin_out(rbin_w));
   fifo_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rp_rst_n), .gray_in(wgray), .bin_out(wbin_r));

   fifo_dpram #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
      .wclk(wr_clk), .we(wr_go), .waddr(wbin[ADDR_W-1:0]), .wdata(wr_data),
      .rclk(rd_clk), .re(rd_load), .raddr(rbin[ADDR_W-1:0]), .rdata(rd_data));

   // ---------------- assertions ----------------
   a_r6_no_overflow: assert property (@(posedge wr_clk) disable iff (!wp_rst_n)
      (wr_en && in_flag == (mode_w == RD_STD)) |=> $stable(wbin));

   a_r6_no_underflow: assert property (@(posedge rd_clk) disable iff (!rp_rst_n)
      (mode_r == RD_STD && rd_en && out_flag) |=> $stable(rbin));

   a_r2_std_hold: assert property (@(posedge rd_clk) disable iff (!rp_rst_n)
      (mode_r == RD_STD && !rd_en) |=> $stable(rd_data));

   a_r4_fwft_hold: assert property (@(posedge rd_clk) disable iff (!rp_rst_n)
      (mode_r == RD_FWFT && out_flag && !rd_en) |=> (out_flag && $stable(rd_data)));

   a_r11_gray_step: assert property (@(posedge wr_clk) disable iff (!wp_rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

   a_r7_half_implies_room_used: assert property (@(posedge wr_clk) disable iff (!wp_rst_n)
      half_full |-> !(wr_free > PW'(DEPTH / 2)));
endmodule

// File: tb/test_fifo_dualmode.sv
`timescale 1ns/1ps
module test_fifo_dualmode;
   localparam int DW = 8;
   localparam int AW = 3;

   logic          wr_clk = 1'b0, rd_clk = 1'b0;
   logic          mrst_n = 1'b0, prst_n = 1'b1, fall_thru_sel = 1'b0;
   logic          wr_en = 1'b0, ofs_load = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] ofs_ae = '0, ofs_af = '0;
   logic [DW-1:0] rd_data;
   logic          out_flag, in_flag, half_full, almost_empty, almost_full;

   int n_chk = 0;
   int n_err = 0;

   fifo_dualmode #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2), .AE_DEF(2), .AF_DEF(2)) i_fifo_dualmode (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .fall_thru_sel(fall_thru_sel), .wr_en(wr_en), .wr_data(wr_data),
      .ofs_load(ofs_load), .ofs_ae(ofs_ae), .ofs_af(ofs_af), .rd_en(rd_en),
      .rd_data(rd_data), .out_flag(out_flag), .in_flag(in_flag),
      .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full));

   // 125 MHz on both sides, read clock phase-shifted
   initial forever #4 wr_clk = ~wr_clk;
   initial begin #3; forever #4 rd_clk = ~rd_clk; end

   // {data, expected half_full, expected almost_full} after each write into DEPTH 8
   localparam logic [DW+1:0] VEC [0:7] = '{
      {8'h11, 1'b0, 1'b0}, {8'h22, 1'b0, 1'b0}, {8'h33, 1'b0, 1'b0}, {8'h44, 1'b0, 1'b0},
      {8'h55, 1'b1, 1'b0}, {8'h66, 1'b1, 1'b1}, {8'h77, 1'b1, 1'b1}, {8'h88, 1'b1, 1'b1}};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic mreset(input logic sel);
      mrst_n = 1'b0;
      fall_thru_sel = sel;
      repeat (4) @(posedge wr_clk);
      @(negedge wr_clk) mrst_n = 1'b1;
      repeat (6) @(negedge wr_clk);
   endtask

   task automatic preset();
      @(negedge wr_clk) prst_n = 1'b0;
      repeat (4) @(posedge wr_clk);
      @(negedge wr_clk) prst_n = 1'b1;
      repeat (6) @(negedge wr_clk);
   endtask

   task automatic push(input logic [DW-1:0] d);
      @(negedge wr_clk) begin wr_en = 1'b1; wr_data = d; end
      @(negedge wr_clk) wr_en = 1'b0;
   endtask

   task automatic pop();
      @(negedge rd_clk) rd_en = 1'b1;
      @(negedge rd_clk) rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge rd_clk);
      repeat (2) @(negedge wr_clk);
      @(negedge rd_clk);
   endtask

   initial begin
      repeat (50000) @(posedge wr_clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      // ---------- standard timing ----------
      mreset(1'b0);
      chk("R9 empty after master reset", out_flag, 1);
      chk("R5 std in_flag not full", in_flag, 0);
      chk("R7 half_full clear", half_full, 0);
      chk("R8 almost_full clear", almost_full, 0);
      chk("R8 almost_empty set", almost_empty, 1);
      fall_thru_sel = 1'b1; // R1: ignored outside master reset

      for (int i = 0; i < 8; i++) begin
         push(VEC[i][DW+1:2]);
         chk($sformatf("R7 half_full after %0d writes", i + 1), half_full, VEC[i][1]);
         chk($sformatf("R8 almost_full after %0d writes", i + 1), almost_full, VEC[i][0]);
      end
      chk("R5 std full", in_flag, 1);
      push(8'hEE); // R6: dropped
      settle();
      chk("R5 std not empty", out_flag, 0);
      chk("R8 almost_empty with 8 words", almost_empty, 0);

      for (int i = 0; i < 8; i++) begin
         pop();
         chk($sformatf("R11 order word %0d", i), rd_data, VEC[i][DW+1:2]);
         if (i == 0) begin
            repeat (5) @(negedge rd_clk);
            chk("R2 R1 std holds without rd_en", rd_data, 8'h11);
         end
      end
      chk("R5 std empty after drain", out_flag, 1);
      pop();
      chk("R6 read on empty leaves data", rd_data, 8'h88);
      settle();
      chk("R6 pointers intact, not full", in_flag, 0);
      chk("R8 almost_empty when empty", almost_empty, 1);

      // ---------- offsets and partial reset ----------
      @(negedge wr_clk) begin ofs_load = 1'b1; ofs_ae = 3'd5; ofs_af = 3'd5; end
      @(negedge wr_clk) ofs_load = 1'b0;
      for (int i = 0; i < 4; i++) push(8'hA1 + 8'(i));
      chk("R8 loaded af offset", almost_full, 1);
      settle();
      chk("R8 loaded ae offset", almost_empty, 1);
      pop();
      chk("R11 first after offsets", rd_data, 8'hA1);

      preset();
      chk("R10 empty after partial reset", out_flag, 1);
      chk("R10 almost_full clear", almost_full, 0);
      for (int i = 0; i < 3; i++) push(8'hB1 + 8'(i));
      chk("R10 af offset kept", almost_full, 1);
      settle();
      chk("R10 standard mode kept", out_flag, 0);
      pop();
      chk("R10 pointers restart", rd_data, 8'hB1);

      // ---------- fall-through timing ----------
      mreset(1'b1);
      chk("R5 fwft no word", out_flag, 0);
      chk("R5 fwft ready", in_flag, 1);

      @(negedge wr_clk) begin wr_en = 1'b1; wr_data = 8'hC1; end
      @(posedge wr_clk);
      #1 wr_en = 1'b0;
      @(posedge rd_clk); #1 chk("R3 edge 1 not yet", out_flag, 0);
      @(posedge rd_clk); #1 chk("R3 edge 2 not yet", out_flag, 0);
      @(posedge rd_clk); #1 chk("R3 edge 3 valid", out_flag, 1);
      chk("R3 first word data", rd_data, 8'hC1);

      push(8'hC2);
      push(8'hC3);
      settle();
      chk("R4 head held", rd_data, 8'hC1);
      chk("R9 ae default restored", almost_empty, 0);
      chk("R9 af default restored", almost_full, 0);
      pop();
      chk("R4 second word", rd_data, 8'hC2);
      chk("R4 still valid", out_flag, 1);
      pop();
      chk("R4 third word", rd_data, 8'hC3);
      pop();
      chk("R4 drop valid when drained", out_flag, 0);

      fall_thru_sel = 1'b0;
      preset();
      chk("R10 fwft kept, no word", out_flag, 0);
      chk("R10 fwft kept, ready", in_flag, 1);
      push(8'hD1);
      settle();
      chk("R10 R1 fall-through after partial reset", out_flag, 1);
      chk("R3 word presented", rd_data, 8'hD1);

      for (int i = 0; i < 8; i++) begin
         push(8'hE0 + 8'(i));
         settle();
      end
      chk("R5 fwft not ready when full", in_flag, 0);
      chk("R7 half_full fwft", half_full, 1);
      push(8'hEE); // R6
      settle();
      for (int i = 0; i < 8; i++) begin
         pop();
         chk($sformatf("R11 fwft order %0d", i), rd_data, 8'hE0 + 8'(i));
      end
      chk("R6 dropped word absent", out_flag, 1);
      pop();
      chk("R4 R6 drained", out_flag, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule